// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects interrupt requests from up to eight devices and presents one of them at a time to a processor. Each device line is watched for a rising edge. A rising edge sets a pending bit. Pending bits pass through a mask, and the lowest-numbered line that is unmasked and not blocked wins. The block then raises a single interrupt output. When the processor pulses acknowledge, the block presents an 8-bit vector in that same cycle. The vector is a programmable base plus the index of the winning line. At the same clock edge the request moves into an in-service set, where it stays until an end-of-interrupt command clears it.

Software sets the block up through two byte-wide write ports: a command port (address 0) and a data port (address 1). A command-port write with bit 4 set starts a sequence of configuration words. The first data write after it gives the vector base. The second data write gives cascade wiring information, which a single controller consumes without using it. An optional third data write gives the mode. Once the sequence ends, data writes load the mask, and a command write of 0x20 retires the most urgent in-service line.

Top module: `intcTop`

## Requirements
- R1: Reset leaves the interrupt output low, every line masked (mask = 0xFF), nothing pending or in service, and the vector base at 0x00.
- R2: A request is latched only on a 0-to-1 transition of its line. A line that is held high raises no new request after its previous one was served.
- R3: Setting bit n of the mask (bit n = line n) keeps a pending request on line n from raising the interrupt output. The request stays latched, so clearing the mask bit later raises the output.
- R4: When several eligible requests are pending, the lowest line index wins (line 0 is the most urgent, line 7 the least).
- R5: While acknowledge is high, the vector output equals base + winning index. At that edge the winning pending bit is cleared and its in-service bit is set, and the interrupt output drops once no eligible request remains.
- R6: A set in-service bit blocks requests on its own line and on all higher-numbered lines. A lower-numbered line can still interrupt, which nests the service.
- R7: A command-port write of 0x20, made outside the configuration sequence, clears only the lowest-indexed set in-service bit.
- R8: A command write with bit 4 set clears mask, pending and in-service state and starts configuration. The next data write is the vector base and the one after it is the cascade word, which has no effect. A further mode word is expected only when bit 0 of the starting command was 1. After that, data writes load the mask.
- R9: When bit 1 of the mode word is 1, acknowledge sets no in-service bit, so a later request of lower priority interrupts without any end-of-interrupt command.
- R10: An acknowledge with no eligible request returns base + 7 and changes no pending or in-service state.
- R11: When an acknowledge and an end-of-interrupt command fall in the same cycle, the command retires the in-service bit that was most urgent before that cycle, and the newly acknowledged line stays in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Device request lines; bit n is line n |
| busWe | input | 1 | Write strobe for the register ports |
| busAddr | input | 1 | 0 selects the command port, 1 the data port |
| busWdata | input | 8 | Write data byte |
| intAck | input | 1 | Processor acknowledge, one cycle per interrupt |
| intOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 8 | Vector number, valid while intAck is high |

## Verification
An acknowledge and an end-of-interrupt command can hit the in-service register in the same cycle. One sets a bit for the new winner while the other clears the bit that was most urgent before the edge. The bench creates this case in two steps. First it serves line 3. Then it raises line 1 and pulses acknowledge in the same cycle as a 0x20 command write. It judges the outcome by raising line 2 afterwards. Line 2 must stay blocked, because line 1 is still in service. It must be delivered only after one more end-of-interrupt command.

// File: rtl/intc_pkg.sv
package intcPkg;
  localparam int DataW = 8;
  localparam logic [DataW-1:0] EoiCode = 8'h20;
  localparam int InitBit = 4;
  localparam int ModeFollowsBit = 0;
  localparam int AutoEoiBit = 1;

  typedef enum logic [1:0] {
    SEQ_READY,
    SEQ_BASE,
    SEQ_LINK,
    SEQ_MODE
  } seqState_t;

  typedef struct packed {
    logic initClear;
    logic baseLoad;
    logic maskLoad;
    logic modeLoad;
    logic eoiCmd;
  } strobes_t;
endpackage

// File: rtl/intc_sequencer.sv
module intcSequencer
  import intcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busAddr,
  input  logic [DataW-1:0] busWdata,
  output strobes_t         stb
);
  seqState_t stateQ;
  logic      modeFollowsQ;
  logic      cmdWr;
  logic      datWr;

  assign cmdWr = busWe & ~busAddr;
  assign datWr = busWe & busAddr;

  always_comb begin
    stb = '0;
    stb.initClear = cmdWr & busWdata[InitBit];
    stb.baseLoad  = datWr & (stateQ == SEQ_BASE);
    stb.modeLoad  = datWr & (stateQ == SEQ_MODE);
    stb.maskLoad  = datWr & (stateQ == SEQ_READY);
    stb.eoiCmd    = cmdWr & (stateQ == SEQ_READY) & (busWdata == EoiCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= SEQ_READY;
      modeFollowsQ <= 1'b0;
    end else if (stb.initClear) begin
      stateQ       <= SEQ_BASE;
      modeFollowsQ <= busWdata[ModeFollowsBit];
    end else if (datWr) begin
      unique case (stateQ)
        SEQ_BASE: stateQ <= SEQ_LINK;
        SEQ_LINK: stateQ <= modeFollowsQ ? SEQ_MODE : SEQ_READY;
        SEQ_MODE: stateQ <= SEQ_READY;
        default:  stateQ <= SEQ_READY;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intcDatapath
  import intcPkg::*;
#(
  parameter int NumIrq = 8,
  parameter int VecW   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumIrq-1:0] irqIn,
  input  logic [VecW-1:0]   wdata,
  input  strobes_t          stb,
  input  logic              intAck,
  output logic              intOut,
  output logic [VecW-1:0]   vectorOut,
  output logic [NumIrq-1:0] reqQ,
  output logic [NumIrq-1:0] maskQ,
  output logic [NumIrq-1:0] svcQ,
  output logic              autoEoiQ
);
  localparam int IdxW = (NumIrq > 1) ? $clog2(NumIrq) : 1;

  logic [NumIrq-1:0] irqPrevQ;
  logic [VecW-1:0]   baseQ;
  logic [NumIrq-1:0] rise;
  logic [NumIrq-1:0] allow;
  logic [NumIrq-1:0] eligible;
  logic [NumIrq-1:0] winOh;
  logic [NumIrq-1:0] ackOh;
  logic [NumIrq-1:0] eoiOh;
  logic [IdxW-1:0]   winIdx;
  logic              seen;

  assign rise = irqIn & ~irqPrevQ;

  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < NumIrq; i++) begin
      seen     = seen | svcQ[i];
      allow[i] = ~seen;
    end
  end

  assign eligible = reqQ & ~maskQ & allow;
  assign winOh    = eligible & (~eligible + 1'b1);
  assign intOut   = |eligible;

  always_comb begin
    winIdx = IdxW'(NumIrq - 1);
    for (int i = 0; i < NumIrq; i++) begin
      if (winOh[i]) winIdx = IdxW'(i);
    end
  end

  assign vectorOut = baseQ + VecW'(winIdx);
  assign ackOh     = intAck ? winOh : '0;
  assign eoiOh     = stb.eoiCmd ? (svcQ & (~svcQ + 1'b1)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrevQ <= '0;
      reqQ     <= '0;
      svcQ     <= '0;
      maskQ    <= '1;
      baseQ    <= '0;
      autoEoiQ <= 1'b0;
    end else begin
      irqPrevQ <= irqIn;
      if (stb.initClear) begin
        reqQ     <= '0;
        svcQ     <= '0;
        maskQ    <= '0;
        autoEoiQ <= 1'b0;
      end else begin
        reqQ <= (reqQ & ~ackOh) | rise;
        svcQ <= (svcQ & ~eoiOh) | (autoEoiQ ? '0 : ackOh);
        if (stb.maskLoad) maskQ <= wdata[NumIrq-1:0];
        if (stb.modeLoad) autoEoiQ <= wdata[AutoEoiBit];
      end
      if (stb.baseLoad) baseQ <= wdata;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intcTop
  import intcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       irqIn,
  input  logic             busWe,
  input  logic             busAddr,
  input  logic [DataW-1:0] busWdata,
  input  logic             intAck,
  output logic             intOut,
  output logic [DataW-1:0] vectorOut
);
  strobes_t   stb;
  logic [7:0] reqReg;
  logic [7:0] maskReg;
  logic [7:0] svcReg;
  logic       autoEoi;

  intcSequencer u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  intcDatapath #(.NumIrq(8), .VecW(DataW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .wdata     (busWdata),
    .stb       (stb),
    .intAck    (intAck),
    .intOut    (intOut),
    .vectorOut (vectorOut),
    .reqQ      (reqReg),
    .maskQ     (maskReg),
    .svcQ      (svcReg),
    .autoEoiQ  (autoEoi)
  );
endmodule

// File: rtl/intc_checker.sv
module intcChecker
  import intcPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     intAck,
  input logic     intOut,
  input strobes_t stb,
  input logic [7:0] reqReg,
  input logic [7:0] maskReg,
  input logic [7:0] svcReg,
  input logic     autoEoi
);
  // R1: reset leaves all lines masked and nothing in service
  p_reset_masked_r1: assert property (@(posedge clk)
    !rstN |=> (maskReg == 8'hFF) && (svcReg == 8'h00));

  // R3: the output needs at least one unmasked pending request
  p_out_unmasked_r3: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((reqReg & ~maskReg) != 8'h00));

  // R5: in-service bits only appear after an acknowledge
  p_svc_from_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> ((svcReg & ~$past(svcReg)) == 8'h00));

  // R5: a served acknowledge leaves a line in service (normal mode)
  p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut && !stb.initClear && !autoEoi) |=> (svcReg != 8'h00));

  // R7: end-of-interrupt retires exactly one in-service line
  p_eoi_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoiCmd && !intAck && (svcReg != 8'h00))
      |=> ($countones(svcReg) == $countones($past(svcReg)) - 1));
endmodule

bind intcTop intcChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .intAck  (intAck),
  .intOut  (intOut),
  .stb     (stb),
  .reqReg  (reqReg),
  .maskReg (maskReg),
  .svcReg  (svcReg),
  .autoEoi (autoEoi)
);

// File: tb/test_intcTop.sv
`timescale 1ns/1ps
module test_intcTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       busWe = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic       intAck = 1'b0;
  logic       intOut;
  logic [7:0] vectorOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intcTop i_intcTop (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .intAck(intAck), .intOut(intOut), .vectorOut(vectorOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk);
    irqIn = irqIn | lines;
    @(negedge clk);
    irqIn = irqIn & ~lines;
  endtask

  task automatic ack(input string req, input logic [7:0] expVec);
    @(negedge clk);
    intAck = 1'b1;
    #1 chk(req, vectorOut, expVec);
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic eoi();
    wr(1'b0, 8'h20);
  endtask

  task automatic testReset();
    chk("R1 out low after reset", {7'b0, intOut}, 8'h00);
    pulse(8'h01);
    chk("R1 all lines masked", {7'b0, intOut}, 8'h00);
    ack("R10 spurious vector base 0", 8'h07);
    chk("R10 nothing raised", {7'b0, intOut}, 8'h00);
  endtask

  task automatic testInit();
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R8 pending cleared by init", {7'b0, intOut}, 8'h00);
    pulse(8'h20);
    chk("R2 edge raises out, R8 mask cleared", {7'b0, intOut}, 8'h01);
    ack("R5 vector base+5", 8'h25);
    chk("R5 out drops after ack", {7'b0, intOut}, 8'h00);
    eoi();
  endtask

  task automatic testPriority();
    pulse(8'h48);
    ack("R4 line 3 beats line 6", 8'h23);
    chk("R6 line 6 blocked by line 3", {7'b0, intOut}, 8'h00);
    pulse(8'h02);
    chk("R6 line 1 nests", {7'b0, intOut}, 8'h01);
    ack("R6 nested vector", 8'h21);
    eoi();
    chk("R7 eoi cleared line 1 only", {7'b0, intOut}, 8'h00);
    eoi();
    chk("R7 second eoi frees line 6", {7'b0, intOut}, 8'h01);
    ack("R4 line 6 served last", 8'h26);
    eoi();
  endtask

  task automatic testMask();
    wr(1'b1, 8'h08);
    pulse(8'h08);
    chk("R3 masked line silent", {7'b0, intOut}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R3 unmask raises latched request", {7'b0, intOut}, 8'h01);
    ack("R3 vector after unmask", 8'h23);
    eoi();
  endtask

  task automatic testLevel();
    @(negedge clk); irqIn[2] = 1'b1;
    @(negedge clk);
    chk("R2 edge on line 2", {7'b0, intOut}, 8'h01);
    ack("R2 vector line 2", 8'h22);
    eoi();
    @(negedge clk);
    chk("R2 held level no new request", {7'b0, intOut}, 8'h00);
    irqIn[2] = 1'b0;
  endtask

  task automatic testCollision();
    pulse(8'h08);
    ack("R11 serve line 3", 8'h23);
    pulse(8'h02);
    @(negedge clk);
    intAck = 1'b1; busWe = 1'b1; busAddr = 1'b0; busWdata = 8'h20;
    #1 chk("R11 vector line 1 in collision", vectorOut, 8'h21);
    @(negedge clk);
    intAck = 1'b0; busWe = 1'b0;
    pulse(8'h04);
    chk("R11 line 1 still in service blocks 2", {7'b0, intOut}, 8'h00);
    eoi();
    chk("R11 line 2 released after eoi", {7'b0, intOut}, 8'h01);
    ack("R11 vector line 2", 8'h22);
    eoi();
  endtask

  task automatic testNoMode();
    wr(1'b0, 8'h10); wr(1'b1, 8'h48); wr(1'b1, 8'h04); wr(1'b1, 8'hFE);
    pulse(8'h02);
    chk("R8 fourth write went to mask", {7'b0, intOut}, 8'h00);
    pulse(8'h01);
    chk("R8 line 0 unmasked", {7'b0, intOut}, 8'h01);
    ack("R8 new base, cascade word ignored", 8'h48);
    eoi();
  endtask

  task automatic testAutoEoi();
    wr(1'b0, 8'h11); wr(1'b1, 8'h60); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    pulse(8'h10);
    ack("R9 vector line 4", 8'h64);
    pulse(8'h20);
    chk("R9 lower line not blocked", {7'b0, intOut}, 8'h01);
    ack("R9 vector line 5", 8'h65);
    ack("R10 spurious base+7", 8'h67);
    chk("R10 state unchanged", {7'b0, intOut}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInit();
    testPriority();
    testMask();
    testLevel();
    testCollision();
    testNoMode();
    testAutoEoi();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule